// File: doc/BRIEF.md
# Parking Bus Arbiter With Idle Timeout

This block decides which master may drive a shared parallel bus. It serves nine external masters, each with an active-low request input and an active-low grant output, plus the bridge's own internal master, which uses an active-high request and grant. At most one grant is active at a time. When no master requests, the grant stays parked on whichever master held it last. Reset parks it on the internal master.

Every external master is placed in a high-priority or a low-priority group by one bit of a priority field. The internal master always belongs to the high group. Any requester in the high group wins over every requester in the low group. Inside a group, masters take turns in ascending index order, with wrap-around.

Ownership moves only while the bus is idle. Between two owners there is one cycle in which no grant is active, so two masters never drive the bus together. A master that holds the grant and requests, but does not start a cycle, loses the grant after a fixed number of idle cycles.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it, the internal master holds the grant (int_gnt=1) and every bit of gnt_n is 1.
- R2: Requester i for i in 0..8 is req_n[i]=0 and is granted by gnt_n[i]=0. The internal master is int_req=1 and int_gnt=1. At most one of the ten grants is active.
- R3: On a clock edge at which no master requests, the active grant stays as it is.
- R4: The grant can only leave its owner on an edge at which bus_idle=1 and frame_start=0.
- R5: A handover drops the old grant after the decision edge. The next edge raises the new grant. This leaves exactly one cycle with no grant.
- R6: prio_sel[i]=1 puts external master i in the high group. The internal master is always high. A requesting high-group master is chosen before any low-group master.
- R7: Inside a group, the next master is the first requester after the group's last granted index, counting up and wrapping past the top.
- R8: An owner that still requests and has not yet started a frame (frame_start=1) since its grant keeps the grant while others wait. Once it has started a frame, or has dropped its request, it yields to any other requester.
- R9: An owner that requests without starting a frame is cut off on its 16th edge with grant, bus_idle=1 and frame_start=0; busy cycles do not count. The grant then passes to the best other requester, or to the internal master if there is none. The cut-off master queues behind the other members of its group.
- R10: After the owner has started a frame, no timeout applies. A sole requester keeps its grant for as long as it requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | 9 | External requests, active low |
| int_req | input | 1 | Internal master request, active high |
| bus_idle | input | 1 | High when no bus cycle is in progress |
| frame_start | input | 1 | High in the cycle the granted master starts a bus cycle |
| prio_sel | input | 9 | Per external master: 1 = high-priority group |
| gnt_n | output | 9 | External grants, active low |
| int_gnt | output | 1 | Internal master grant, active high |

## Verification
The assertions rely on frame_start coming only from the current owner and only while it holds the grant. They also rely on bus_idle reporting the bus's real state. The handover and park properties are stated against these two inputs. The stimulus drives frame_start only for the master that the bench expects to hold the grant, and only while a grant is active. It drives bus_idle low only in stretches where no handover is expected.

// File: rtl/arb_pkg.sv
package arb_pkg;

   // grant machine: a grant is held, or the bus passes through one empty cycle
   typedef enum logic {
      ST_GRANT = 1'b0,
      ST_GAP   = 1'b1
   } arb_state_e;

   // group numbers used to index round-robin pointers
   localparam logic GRP_HIGH = 1'b0;
   localparam logic GRP_LOW  = 1'b1;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int N  = 10,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] ptr,
   output logic          found,
   output logic [IW-1:0] idx
);

   logic [IW:0] probe;

   // scan upward from the slot after ptr, wrapping, and take the first requester
   always_comb begin
      found = 1'b0;
      idx   = '0;
      probe = '0;
      for (int off = 1; off <= N; off++) begin
         probe = {1'b0, ptr} + (IW+1)'(off);
         if (probe >= (IW+1)'(N)) probe = probe - (IW+1)'(N);
         if (!found && req[probe[IW-1:0]]) begin
            found = 1'b1;
            idx   = probe[IW-1:0];
         end
      end
   end

endmodule

// File: rtl/arb_idle_timer.sv
module arb_idle_timer #(
   parameter int LIMIT = 16,
   parameter int CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic expire
);

   logic [CW-1:0] cnt_q;

   assign expire = en && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr || expire) cnt_q <= '0;
      else if (en)            cnt_q <= cnt_q + 1'b1;
   end

   // the owner's grant is dropped after an expiry, so it cannot fire twice in a row
   p_expire_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
   import arb_pkg::*;
#(
   parameter int N_EXT      = 9,
   parameter int IDLE_LIMIT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] req_n,
   input  logic             int_req,
   input  logic             bus_idle,
   input  logic             frame_start,
   input  logic [N_EXT-1:0] prio_sel,
   output logic [N_EXT-1:0] gnt_n,
   output logic             int_gnt
);

   localparam int NM      = N_EXT + 1;
   localparam int IW      = $clog2(NM);
   localparam int INT_IDX = N_EXT;

   if (N_EXT < 1 || N_EXT > 31) begin : g_bad_count
      $error("bus_arbiter: N_EXT out of range");
   end
   if (IDLE_LIMIT < 2) begin : g_bad_limit
      $error("bus_arbiter: IDLE_LIMIT must be at least 2");
   end

   arb_state_e    state_q;
   logic [IW-1:0] owner_q;
   logic          used_q;
   logic [IW-1:0] ptr_q [2];

   logic [NM-1:0] req_vec, grp_hi, own_oh, cand, gv;
   logic [1:0]    g_found;
   logic [IW-1:0] g_idx [2];
   logic          win_valid, win_grp, own_grp, owner_req;
   logic [IW-1:0] winner;
   logic          tmr_en, tmr_clr, expire, switch_go;

   assign req_vec = {int_req, ~req_n};
   assign grp_hi  = {1'b1, prio_sel};

   always_comb begin
      own_oh          = '0;
      own_oh[owner_q] = 1'b1;
   end

   assign gv        = (state_q == ST_GRANT) ? own_oh : '0;
   assign gnt_n     = ~gv[N_EXT-1:0];
   assign int_gnt   = gv[INT_IDX];
   assign owner_req = req_vec[owner_q];
   assign cand      = req_vec & ~own_oh;

   // one picker per priority group
   for (genvar g = 0; g < 2; g++) begin : g_grp
      logic [NM-1:0] grp_req;
      assign grp_req = (g == 0) ? (cand & grp_hi) : (cand & ~grp_hi);
      arb_rr_pick #(.N(NM), .IW(IW)) u_pick (
         .req   (grp_req),
         .ptr   (ptr_q[g]),
         .found (g_found[g]),
         .idx   (g_idx[g])
      );
   end

   assign win_valid = |g_found;
   assign win_grp   = g_found[0] ? GRP_HIGH : GRP_LOW;
   assign winner    = g_found[0] ? g_idx[0] : g_idx[1];
   assign own_grp   = grp_hi[owner_q] ? GRP_HIGH : GRP_LOW;

   // count only for an owner still waiting to start its first frame
   assign tmr_en  = (state_q == ST_GRANT) && owner_req && !used_q &&
                    bus_idle && !frame_start;
   assign tmr_clr = (state_q != ST_GRANT) || frame_start;

   arb_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tmr_clr),
      .en     (tmr_en),
      .expire (expire)
   );

   assign switch_go = (state_q == ST_GRANT) && bus_idle && !frame_start &&
                      win_valid && (!owner_req || used_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_GRANT;
         owner_q  <= IW'(INT_IDX);
         used_q   <= 1'b0;
         ptr_q[0] <= IW'(INT_IDX);
         ptr_q[1] <= IW'(INT_IDX);
      end else begin
         case (state_q)
            ST_GAP: begin
               state_q <= ST_GRANT;
            end
            default: begin
               if (expire) begin
                  state_q          <= ST_GAP;
                  used_q           <= 1'b0;
                  ptr_q[own_grp]   <= owner_q;
                  owner_q          <= win_valid ? winner : IW'(INT_IDX);
                  if (win_valid) ptr_q[win_grp] <= winner;
               end else if (switch_go) begin
                  state_q        <= ST_GAP;
                  used_q         <= 1'b0;
                  owner_q        <= winner;
                  ptr_q[win_grp] <= winner;
               end else if (frame_start) begin
                  used_q <= 1'b1;
               end
            end
         endcase
      end
   end

   // ---------------- assertions ----------------
   p_gap_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(gv) == '0) |-> (gv != '0));

   p_no_direct_handover_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((gv != '0) && ($past(gv) != '0)) |-> (gv == $past(gv)));

   p_move_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(gv) != '0) && (gv != $past(gv))) |->
         ($past(bus_idle) && !$past(frame_start)));

   p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(req_vec) == '0) && ($past(gv) != '0)) |-> (gv == $past(gv)));

   p_new_grant_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(gv) == '0) |-> (((gv & $past(req_vec, 2)) != '0) || gv[INT_IDX]));

   p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({int_gnt, ~gnt_n}));

endmodule

// File: tb/tb_bus_arbiter.sv
module tb_bus_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam int NX = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NX-1:0] req_n = '1;
   logic          int_req = 1'b0;
   logic          bus_idle = 1'b1;
   logic          frame_start = 1'b0;
   logic [NX-1:0] prio_sel = '0;
   logic [NX-1:0] gnt_n;
   logic          int_gnt;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [NX:0] exp_q [$];
   string       tag_q [$];

   bus_arbiter dut (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .int_req(int_req),
      .bus_idle(bus_idle), .frame_start(frame_start), .prio_sel(prio_sel),
      .gnt_n(gnt_n), .int_gnt(int_gnt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [NX:0] grants();
      return {int_gnt, ~gnt_n};
   endfunction

   task automatic check(input logic [NX:0] act, input logic [NX:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: grant vector %h, expected %h", tag, act, exp);
      end
   endtask

   // drive one cycle; exp is the grant vector expected after the coming edge
   task automatic drive(input logic [NX:0] req, input logic idle, input logic fs,
                        input logic [NX:0] exp, input string tag);
      @(negedge clk);
      req_n       = ~req[NX-1:0];
      int_req     = req[NX];
      bus_idle    = idle;
      frame_start = fs;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (exp_q.size() > 0) check(grants(), exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(grants(), 10'h200, "R1 in reset");
      rst_n = 1'b1;
      @(posedge clk); #(CLK_PERIOD/4);
      check(grants(), 10'h200, "R1 after reset");

      // R3 parking with no requests
      for (int i = 0; i < 3; i++) drive(10'h000, 1'b1, 1'b0, 10'h200, "R3 park internal");

      // R4 bus busy blocks the move, then R5 gap and new grant, R2 polarity
      drive(10'h008, 1'b0, 1'b0, 10'h200, "R4 busy holds");
      drive(10'h008, 1'b0, 1'b0, 10'h200, "R4 busy holds");
      drive(10'h008, 1'b1, 1'b0, 10'h000, "R5 gap cycle");
      drive(10'h008, 1'b1, 1'b0, 10'h008, "R2 R5 grant to 3");
      drive(10'h000, 1'b1, 1'b0, 10'h008, "R3 park on 3");

      // R6 priority groups, R8 owner keeps grant until it starts a frame
      prio_sel = 9'h020;
      drive(10'h022, 1'b1, 1'b0, 10'h000, "R6 gap");
      drive(10'h022, 1'b1, 1'b0, 10'h020, "R6 high group 5 wins");
      drive(10'h022, 1'b1, 1'b1, 10'h020, "R4 frame start holds");
      drive(10'h022, 1'b0, 1'b0, 10'h020, "R4 busy holds");
      drive(10'h022, 1'b1, 1'b0, 10'h000, "R8 yields after frame");
      drive(10'h022, 1'b1, 1'b0, 10'h002, "R8 grant to 1");

      // R7 round robin with wrap in the low group
      prio_sel = 9'h000;
      drive(10'h085, 1'b1, 1'b0, 10'h000, "R7 gap");
      drive(10'h085, 1'b1, 1'b0, 10'h004, "R7 next after 1 is 2");
      drive(10'h085, 1'b1, 1'b1, 10'h004, "R8 frame by 2");
      drive(10'h081, 1'b1, 1'b0, 10'h000, "R7 gap");
      drive(10'h081, 1'b1, 1'b0, 10'h080, "R7 next after 2 is 7");
      drive(10'h081, 1'b1, 1'b1, 10'h080, "R8 frame by 7");
      drive(10'h081, 1'b1, 1'b0, 10'h000, "R7 gap");
      drive(10'h081, 1'b1, 1'b0, 10'h001, "R7 wrap to 0");

      // R9 timeout with no other requester falls back to internal
      for (int i = 1; i <= 15; i++) drive(10'h001, 1'b1, 1'b0, 10'h001, "R9 before limit");
      drive(10'h001, 1'b1, 1'b0, 10'h000, "R9 revoke at 16");
      drive(10'h001, 1'b1, 1'b0, 10'h200, "R9 internal after revoke");
      drive(10'h003, 1'b1, 1'b0, 10'h000, "R9 gap");
      drive(10'h003, 1'b1, 1'b0, 10'h002, "R9 revoked 0 queues behind 1");

      // R9 busy cycles do not count, R8 waiter held until timeout
      for (int i = 1; i <= 17; i++) begin
         drive(10'h012, (i == 5 || i == 6) ? 1'b0 : 1'b1, 1'b0, 10'h002, "R9 R8 owner 1 held");
      end
      drive(10'h012, 1'b1, 1'b0, 10'h000, "R9 revoke with waiter");
      drive(10'h012, 1'b1, 1'b0, 10'h010, "R9 waiter 4 granted");

      // R10 after a frame, a sole requester is never cut off
      for (int i = 0; i < 5; i++) drive(10'h010, 1'b1, 1'b0, 10'h010, "R10 before frame");
      drive(10'h010, 1'b1, 1'b1, 10'h010, "R10 frame by 4");
      for (int i = 0; i < 20; i++) drive(10'h010, 1'b1, 1'b0, 10'h010, "R10 no timeout");

      // R6 internal master is always high priority
      drive(10'h204, 1'b1, 1'b0, 10'h000, "R6 gap");
      drive(10'h204, 1'b1, 1'b0, 10'h200, "R6 internal beats low 2");

      drive(10'h000, 1'b1, 1'b0, 10'h200, "R3 park internal");
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule